// File: doc/BRIEF.md
# Long-Word Read Unpacker

This block splits 36-bit entries from a first-word-fall-through memory into narrower pieces for a port. The port runs either as an 18-bit word bus, taking two pieces per entry, or as a 9-bit byte bus, taking four pieces per entry. The piece order is either most-significant first (big-endian) or least-significant first (little-endian).

The bus size and the order are captured while reset is held. The values present on the last clock edge before reset is released stay in force until the next reset. Changes to those inputs after release have no effect.

The block has two named states:
- `ST_IDLE`: no long word is held.
- `ST_SERVE`: a long word sits in the holding register and the piece it points to is shown on the port.

The transitions are:
- `ST_IDLE` to `ST_SERVE`, called *fetch*. It happens when the memory is not empty. The entry is popped and loaded into the holding register.
- `ST_SERVE` to `ST_SERVE`, called *advance*. A port read of a piece that is not the last one moves the piece index forward. The memory is not popped.
- `ST_SERVE` to `ST_SERVE`, called *refill*. A port read of the last piece while the memory holds data pops the next entry in the same cycle.
- `ST_SERVE` to `ST_IDLE`, called *drain*. A port read of the last piece while the memory is empty returns the block to `ST_IDLE`.

Top module: `long_unpacker`

## Requirements
- R1: While reset is asserted, `mem_pop` and `rd_valid` are 0 and `rd_data` is all zeros, even when the memory is not empty. Whenever `rd_valid` is 0, `rd_data` is 0.
- R2: In `ST_IDLE` with `mem_empty` low, `mem_pop` is 1 in that same cycle. On the next cycle `rd_valid` is 1 and the first piece of the popped entry is shown.
- R3: In word mode (`cfg_byte_mode`=0) with big-endian order (`cfg_big_endian`=1), the pieces come out as bits 35:18 first, then bits 17:0.
- R4: In word mode with little-endian order (`cfg_big_endian`=0), the pieces come out as bits 17:0 first, then bits 35:18.
- R5: In byte mode (`cfg_byte_mode`=1) with big-endian order, the pieces come out as bits 35:27, 26:18, 17:9 and then 8:0. Each byte is placed on `rd_data[8:0]`, and `rd_data[17:9]` is 0.
- R6: In byte mode with little-endian order, the pieces come out as bits 8:0, 17:9, 26:18 and then 35:27. Each byte is placed on `rd_data[8:0]`, and the upper lanes are 0.
- R7: The memory is popped exactly once per long word. `mem_pop` stays 0 while the pieces after the first are being read.
- R8: A port read of the last piece while the memory is not empty raises `mem_pop` in that cycle. The next cycle shows the first piece of the new entry, with no gap in `rd_valid`.
- R9: A port read while no word is held (`rd_valid`=0) is ignored and does not advance the piece order of a later entry. `mem_pop` is never 1 while `mem_empty` is 1.
- R10: While `rd_valid` is 1 and `rd_en` is 0, `rd_data` and `rd_valid` stay unchanged.
- R11: The bus size and endian order are the values of `cfg_byte_mode` and `cfg_big_endian` on the last clock edge with reset asserted. Changing those inputs afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; configuration is captured while low |
| cfg_byte_mode | input | 1 | 1 selects the 9-bit byte bus, 0 selects the 18-bit word bus |
| cfg_big_endian | input | 1 | 1 sends the most significant piece first |
| mem_empty | input | 1 | Memory holds no entry |
| mem_data | input | 36 | Head entry of the memory (first-word fall-through) |
| mem_pop | output | 1 | Removes the head entry at this clock edge |
| rd_en | input | 1 | Port read; consumes the piece currently shown |
| rd_data | output | 18 | Piece shown on the port |
| rd_valid | output | 1 | A valid piece is shown |

## Verification
All four combinations of bus size and order are applied to the same long word. Each byte lane carries a distinct value, so a swapped half, a reversed byte order or a wrong lane shows up as a specific mismatch. In every run the configuration inputs are flipped just as reset is released, which separates configuration captured at release from configuration that follows the live inputs. Directed sequences cover several further cases:
- a memory that is already non-empty while reset is held;
- port reads against an empty memory;
- a stalled read;
- two entries read back to back, which separates a pop taken at the word boundary from a pop that is late or repeated.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } unpk_state_e;
endpackage

// File: rtl/unpk_cfg_latch.sv
// Captures bus size and order on every edge while reset is low, then holds them.
module unpk_cfg_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_mode_in,
    input  logic big_endian_in,
    output logic byte_mode_q,
    output logic big_endian_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_mode_q  <= byte_mode_in;
            big_endian_q <= big_endian_in;
        end
    end
endmodule

// File: rtl/unpk_piece_sel.sv
// Selects the piece of the held long word that the index points to.
module unpk_piece_sel #(
    parameter int PIECE_W   = 9,
    parameter int NUM_LANES = 4
) (
    input  logic [PIECE_W*NUM_LANES-1:0]     long_word,
    input  logic [$clog2(NUM_LANES)-1:0]     idx,
    input  logic                             byte_mode,
    input  logic                             big_endian,
    output logic [PIECE_W*NUM_LANES/2-1:0]   piece
);
    localparam int LONG_W = PIECE_W * NUM_LANES;
    localparam int WORD_W = LONG_W / 2;
    localparam int IDX_W  = $clog2(NUM_LANES);

    logic [PIECE_W-1:0] lane [NUM_LANES];
    logic [WORD_W-1:0]  half [2];

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign lane[g] = long_word[g*PIECE_W +: PIECE_W];
    end
    for (genvar h = 0; h < 2; h++) begin : g_half
        assign half[h] = long_word[h*WORD_W +: WORD_W];
    end

    logic [IDX_W-1:0] lane_sel;
    logic             half_sel;

    always_comb begin
        lane_sel = big_endian ? (IDX_W'(NUM_LANES - 1) - idx) : idx;
        half_sel = big_endian ? ~idx[0] : idx[0];
        if (byte_mode) begin
            piece = {{(WORD_W - PIECE_W){1'b0}}, lane[lane_sel]};
        end else begin
            piece = half[half_sel];
        end
    end
endmodule

// File: rtl/unpk_fsm.sv
// Sequencing: when to pop, which piece index is current.
module unpk_fsm
    import unpk_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mem_empty,
    input  logic                         rd_en,
    input  logic                         byte_mode,
    output logic                         load,
    output logic                         serving,
    output logic [$clog2(NUM_LANES)-1:0] idx
);
    localparam int IDX_W = $clog2(NUM_LANES);

    unpk_state_e      state_q, state_d;
    logic [IDX_W-1:0] idx_d;
    logic [IDX_W-1:0] last_idx;
    logic             at_last;
    logic             take;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx     <= '0;
        end else begin
            state_q <= state_d;
            idx     <= idx_d;
        end
    end

    // next state and outputs
    always_comb begin
        last_idx = byte_mode ? IDX_W'(NUM_LANES - 1) : IDX_W'(1);
        at_last  = (idx == last_idx);
        take     = (state_q == ST_SERVE) && rd_en;
        load     = 1'b0;
        state_d  = state_q;
        idx_d    = idx;
        unique case (state_q)
            ST_IDLE: begin
                if (rst_n && !mem_empty) begin       // fetch
                    load    = 1'b1;
                    state_d = ST_SERVE;
                    idx_d   = '0;
                end
            end
            ST_SERVE: begin
                if (take && !at_last) begin          // advance
                    idx_d = idx + 1'b1;
                end else if (take && at_last) begin
                    idx_d = '0;
                    if (rst_n && !mem_empty) begin   // refill
                        load = 1'b1;
                    end else begin                   // drain
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
        serving = (state_q == ST_SERVE);
    end
endmodule

// File: rtl/long_unpacker.sv
module long_unpacker #(
    parameter int PIECE_W   = 9,
    parameter int NUM_LANES = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_byte_mode,
    input  logic                           cfg_big_endian,
    input  logic                           mem_empty,
    input  logic [PIECE_W*NUM_LANES-1:0]   mem_data,
    output logic                           mem_pop,
    input  logic                           rd_en,
    output logic [PIECE_W*NUM_LANES/2-1:0] rd_data,
    output logic                           rd_valid
);
    localparam int LONG_W = PIECE_W * NUM_LANES;
    localparam int WORD_W = LONG_W / 2;
    localparam int IDX_W  = $clog2(NUM_LANES);

    logic              byte_q;
    logic              big_q;
    logic              load;
    logic              serving;
    logic [IDX_W-1:0]  idx;
    logic [LONG_W-1:0] hold_q;
    logic [WORD_W-1:0] piece;

    unpk_cfg_latch u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_mode_in (cfg_byte_mode),
        .big_endian_in(cfg_big_endian),
        .byte_mode_q  (byte_q),
        .big_endian_q (big_q)
    );

    unpk_fsm #(.NUM_LANES(NUM_LANES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_empty(mem_empty),
        .rd_en    (rd_en),
        .byte_mode(byte_q),
        .load     (load),
        .serving  (serving),
        .idx      (idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (load) begin
            hold_q <= mem_data;
        end
    end

    unpk_piece_sel #(.PIECE_W(PIECE_W), .NUM_LANES(NUM_LANES)) u_sel (
        .long_word (hold_q),
        .idx       (idx),
        .byte_mode (byte_q),
        .big_endian(big_q),
        .piece     (piece)
    );

    always_comb begin
        mem_pop  = load;
        rd_valid = serving;
        rd_data  = serving ? piece : '0;
    end
endmodule

// File: rtl/unpk_checker.sv
module unpk_checker #(
    parameter int PIECE_W   = 9,
    parameter int NUM_LANES = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           mem_empty,
    input logic                           mem_pop,
    input logic                           rd_en,
    input logic                           rd_valid,
    input logic [PIECE_W*NUM_LANES/2-1:0] rd_data,
    input logic                           cfg_byte_q
);
    localparam int IDX_W = $clog2(NUM_LANES);

    logic [IDX_W-1:0] cnt;
    logic [IDX_W-1:0] last;

    assign last = cfg_byte_q ? IDX_W'(NUM_LANES - 1) : IDX_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (mem_pop) cnt <= '0;
        else if (rd_valid && rd_en) cnt <= (cnt == last) ? '0 : cnt + 1'b1;
    end

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_data == '0); // R1
    AST_POP_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        mem_pop |=> rd_valid); // R2
    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && cfg_byte_q) |-> rd_data[PIECE_W*NUM_LANES/2-1:PIECE_W] == '0); // R5
    AST_POP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_pop |-> (!rd_valid || (rd_en && cnt == last))); // R7
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_pop |-> !mem_empty); // R9
    AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data))); // R10
endmodule

bind long_unpacker unpk_checker #(.PIECE_W(PIECE_W), .NUM_LANES(NUM_LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_empty (mem_empty),
    .mem_pop   (mem_pop),
    .rd_en     (rd_en),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .cfg_byte_q(byte_q)
);

// File: tb/long_unpacker_bench.sv
module long_unpacker_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_byte_mode, cfg_big_endian;
    logic        mem_empty;
    logic [35:0] mem_data;
    logic        mem_pop;
    logic        rd_en;
    logic [17:0] rd_data;
    logic        rd_valid;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    // simple first-word-fall-through memory model
    logic [35:0] mem [8];
    int wr_n = 0;
    int rd_n = 0;
    assign mem_empty = (rd_n == wr_n);
    assign mem_data  = mem[rd_n % 8];
    always @(posedge clk) if (mem_pop) rd_n <= rd_n + 1;

    long_unpacker u_long_unpacker (
        .clk(clk), .rst_n(rst_n), .cfg_byte_mode(cfg_byte_mode),
        .cfg_big_endian(cfg_big_endian), .mem_empty(mem_empty),
        .mem_data(mem_data), .mem_pop(mem_pop), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // lanes b3..b0 of W0 and W1
    localparam logic [35:0] W0 = {9'h1A1, 9'h0B2, 9'h1C3, 9'h0D4};
    localparam logic [35:0] W1 = {9'h155, 9'h0AA, 9'h13C, 9'h0C3};
    localparam logic [17:0] HI = {9'h1A1, 9'h0B2};
    localparam logic [17:0] LO = {9'h1C3, 9'h0D4};

    typedef struct packed {
        logic        bm;
        logic        be;
        logic [71:0] exp;   // piece0..piece3, 18 bits each
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{bm: 1'b0, be: 1'b1, exp: {HI, LO, 36'h0}},
        '{bm: 1'b0, be: 1'b0, exp: {LO, HI, 36'h0}},
        '{bm: 1'b1, be: 1'b1, exp: {9'h0, 9'h1A1, 9'h0, 9'h0B2, 9'h0, 9'h1C3, 9'h0, 9'h0D4}},
        '{bm: 1'b1, be: 1'b0, exp: {9'h0, 9'h0D4, 9'h0, 9'h1C3, 9'h0, 9'h0B2, 9'h0, 9'h1A1}}
    };

    task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(input logic [35:0] w);
        mem[wr_n % 8] = w;
        wr_n++;
    endtask

    // ends on a negedge just after release; cfg flipped at release (R11)
    task automatic do_reset(input logic bm, input logic be);
        rst_n = 1'b0; rd_en = 1'b0;
        cfg_byte_mode = bm; cfg_big_endian = be;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cfg_byte_mode = ~bm; cfg_big_endian = ~be;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rd_en = 1'b0; cfg_byte_mode = 1'b0; cfg_big_endian = 1'b1;

        // vector table: order per mode (R3 R4 R5 R6), config held after release (R11)
        for (int e = 0; e < 4; e++) begin
            string req;
            int    n;
            int    base;
            req = VEC[e].bm ? (VEC[e].be ? "R5/R11" : "R6/R11") : (VEC[e].be ? "R3/R11" : "R4/R11");
            n   = VEC[e].bm ? 4 : 2;
            do_reset(VEC[e].bm, VEC[e].be);
            push(W0);
            #4 check(mem_pop === 1'b1, "R2", 36'(mem_pop), 36'h1);
            @(negedge clk);
            base = rd_n;
            for (int k = 0; k < n; k++) begin
                rd_en = 1'b1;
                #4;
                check(rd_valid === 1'b1, req, 36'(rd_valid), 36'h1);
                check(rd_data === VEC[e].exp[71-18*k -: 18], req, 36'(rd_data), 36'(VEC[e].exp[71-18*k -: 18]));
                check(mem_pop === 1'b0, "R7", 36'(mem_pop), 36'h0);
                @(negedge clk);
            end
            rd_en = 1'b0;
            #4;
            check(rd_valid === 1'b0 && rd_data === 18'h0, "R1", 36'(rd_data), 36'h0);
            check(rd_n == base, "R7", 36'(rd_n - base), 36'h0);
            @(negedge clk);
        end

        // R1: memory non-empty during reset must not be popped
        rst_n = 1'b0; rd_en = 1'b0; cfg_byte_mode = 1'b0; cfg_big_endian = 1'b1;
        push(W0);
        repeat (2) @(negedge clk);
        #4;
        check(mem_pop === 1'b0, "R1", 36'(mem_pop), 36'h0);
        check(rd_valid === 1'b0 && rd_data === 18'h0, "R1", 36'(rd_data), 36'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #4 check(rd_valid === 1'b1 && rd_data === HI, "R2", 36'(rd_data), 36'(HI));
        @(negedge clk);
        rd_en = 1'b1;
        repeat (2) @(negedge clk);
        rd_en = 1'b0;

        // R9: reads with nothing held are ignored
        rd_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #4;
            check(rd_valid === 1'b0, "R9", 36'(rd_valid), 36'h0);
            check(mem_pop === 1'b0, "R9", 36'(mem_pop), 36'h0);
            @(negedge clk);
        end
        rd_en = 1'b0;
        push(W0);
        @(negedge clk);
        #4 check(rd_data === HI, "R9", 36'(rd_data), 36'(HI));
        @(negedge clk);
        // R10: stall keeps the piece
        for (int i = 0; i < 3; i++) begin
            #4 check(rd_valid === 1'b1 && rd_data === HI, "R10", 36'(rd_data), 36'(HI));
            @(negedge clk);
        end
        rd_en = 1'b1;
        #4 check(rd_data === HI, "R10", 36'(rd_data), 36'(HI));
        @(negedge clk);
        #4 check(rd_data === LO, "R3", 36'(rd_data), 36'(LO));
        @(negedge clk);
        rd_en = 1'b0;

        // R8: two entries back to back in byte big-endian mode
        do_reset(1'b1, 1'b1);
        begin
            int base;
            push(W0); push(W1);
            @(negedge clk);
            base = rd_n;
            rd_en = 1'b1;
            for (int k = 0; k < 3; k++) @(negedge clk);
            #4;
            check(rd_data === {9'h0, 9'h0D4}, "R5", 36'(rd_data), 36'h0D4);
            check(mem_pop === 1'b1, "R8", 36'(mem_pop), 36'h1);
            @(negedge clk);
            #4 check(rd_valid === 1'b1 && rd_data === {9'h0, 9'h155}, "R8", 36'(rd_data), 36'h155);
            check(rd_n == base + 1, "R7", 36'(rd_n - base), 36'h1);
            @(negedge clk);
            #4 check(rd_data === {9'h0, 9'h0AA}, "R8", 36'(rd_data), 36'h0AA);
            repeat (3) @(negedge clk);
            rd_en = 1'b0;
            #4 check(rd_valid === 1'b0, "R8", 36'(rd_valid), 36'h0);
            check(rd_n == base + 1, "R7", 36'(rd_n - base), 36'h1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule